// File: doc/BRIEF.md
# Data-Processing Execute Unit

A purely combinational execute stage for one 32-bit data-processing instruction word. The caller supplies the instruction word, the register values already read for the first-operand and second-operand registers, and the current N, Z, C and V flags. The unit builds the second operand in one of two ways, chosen by one instruction bit: an 8-bit constant rotated right, or the second register shifted by a 5-bit constant. It then applies one of sixteen arithmetic or logical operations to the two operands.

It returns the 32-bit result, the destination register index, a write enable for that register, the next flag values and a flag write enable. Four of the opcodes are tests and compares. They compute a value only to set the flags, and they never write a register. Register storage, fetch, condition evaluation and shifts by a register-held amount are handled outside this unit.

Top module: `dpx_exec_unit`

## Requirements
- R1: Instruction fields: immediate-select at bit 25, opcode at [24:21], set-flags at bit 20, first-operand register at [19:16], destination at [15:12], operand-2 field at [11:0]. `rd_idx_o` equals bits [15:12]. Bits [31:26] have no effect on any output.
- R2: With bit 25 = 1, operand 2 is bits [7:0] zero-extended and rotated right by twice the value in [11:8]. The shifter carry is bit 31 of that operand when the rotate field is nonzero. Otherwise it is the incoming C.
- R3: With bit 25 = 0, the second register value is shifted by the amount in [11:7], using the shift kind in [6:5]: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. The shifter carry is the last bit shifted out. An amount of 0 passes the value through unchanged and the carry is the incoming C. Bit 4 has no effect.
- R4: Logical opcodes: 0000 AND, 0001 XOR, 1100 OR, 1101 move (operand 2), 1110 first operand AND NOT operand 2, 1111 NOT operand 2. Tests 1000 (AND) and 1001 (XOR) compute the same values as 0000 and 0001.
- R5: Arithmetic opcodes: 0010 op1-op2, 0011 op2-op1, 0100 op1+op2, 0101 op1+op2+C, 0110 op1-op2-1+C, 0111 op2-op1-1+C. Compares 1010 (op1-op2) and 1011 (op1+op2) compute the same values as 0010 and 0100.
- R6: Opcodes 10xx drive `rd_we_o` low and `flags_we_o` high whatever the set-flags bit is. Every other opcode drives `rd_we_o` high.
- R7: For opcodes other than 10xx with set-flags = 0, `flags_we_o` is low and `flags_o` equals `flags_i`.
- R8: Whenever flags are written, N equals result bit 31 and Z is 1 exactly when the result is zero.
- R9: For arithmetic opcodes, C is the carry out of the addition actually performed (subtraction adds the inverted operand, so 1 means no borrow). V is set on signed overflow of that addition.
- R10: For logical opcodes, C is the shifter carry from R2 or R3 and V keeps its incoming value.
- R11: Move and NOT-move results do not depend on the first-operand value.
- R12: Flag bit order on `flags_i` and `flags_o` is N=3, Z=2, C=1, V=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Data-processing instruction word |
| rn_val_i | input | 32 | Value of the first-operand register |
| rm_val_i | input | 32 | Value of the second-operand register |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | 32 | Operation result |
| rd_idx_o | output | 4 | Destination register index |
| rd_we_o | output | 1 | Destination register write enable |
| flags_o | output | 4 | Next flags {N,Z,C,V} |
| flags_we_o | output | 1 | Flag write enable |

## Verification
The unit holds no state, so every output is due in the same cycle as the inputs that produce it. No register sits between an input and an output. The bench drives each new instruction and operand set just after a falling clock edge. It then waits a fixed 1 ns for the logic to settle and samples every output before the next rising edge. Each scenario is driven, settled and checked before the next scenario is applied.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00, SH_LSR = 2'b01, SH_ASR = 2'b10, SH_ROR = 2'b11
  } shift_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam int unsigned FLD_IMM  = 25;
  localparam int unsigned FLD_OPC  = 21;
  localparam int unsigned FLD_SET  = 20;
  localparam int unsigned FLD_RN   = 16;
  localparam int unsigned FLD_RD   = 12;
  localparam int unsigned OP2_W    = 12;
  localparam int unsigned RIDX_W   = 4;

  function automatic logic is_test(alu_op_e op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic is_arith(alu_op_e op);
    return (op[3:2] == 2'b01) || (op[3:1] == 3'b001) || (op[3:1] == 3'b101);
  endfunction

endpackage

// File: rtl/dpx_operand2.sv
module dpx_operand2
  import dpx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              imm_sel_i,
  input  logic [OP2_W-1:0]  field_i,
  input  logic [DATA_W-1:0] rm_val_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] op2_o,
  output logic              shc_o
);
  localparam int unsigned SHAMT_W = $clog2(DATA_W);
  localparam int unsigned IMM_W   = 8;
  localparam int unsigned ROT_W   = 4;

  function automatic logic [DATA_W-1:0] rotr(logic [DATA_W-1:0] v, logic [SHAMT_W-1:0] a);
    return (v >> a) | (v << (DATA_W - int'(a)));
  endfunction

  logic [IMM_W-1:0]   imm8;
  logic [ROT_W-1:0]   rot4;
  logic [SHAMT_W-1:0] rot_amt;
  logic [DATA_W-1:0]  imm_val;
  logic               imm_c;

  logic [SHAMT_W-1:0] sh_amt;
  shift_e             sh_kind;
  logic [DATA_W-1:0]  reg_val;
  logic               reg_c;
  logic [DATA_W:0]    wide;
  logic               unused_bit4;

  assign imm8        = field_i[IMM_W-1:0];
  assign rot4        = field_i[OP2_W-1:IMM_W];
  assign rot_amt     = SHAMT_W'({rot4, 1'b0});
  assign sh_amt      = field_i[OP2_W-1:OP2_W-SHAMT_W];
  assign sh_kind     = shift_e'(field_i[6:5]);
  assign unused_bit4 = field_i[4];

  // immediate path
  always_comb begin
    imm_val = rotr(DATA_W'(imm8), rot_amt);
    imm_c   = (rot4 == '0) ? c_i : imm_val[DATA_W-1];
  end

  // register path, constant shift amount
  always_comb begin
    reg_val = rm_val_i;
    reg_c   = c_i;
    wide    = '0;
    if (sh_amt != '0) begin
      unique case (sh_kind)
        SH_LSL: begin
          wide    = {1'b0, rm_val_i} << sh_amt;
          reg_val = wide[DATA_W-1:0];
          reg_c   = wide[DATA_W];
        end
        SH_LSR: begin
          wide    = {rm_val_i, 1'b0} >> sh_amt;
          reg_val = wide[DATA_W:1];
          reg_c   = wide[0];
        end
        SH_ASR: begin
          wide    = $unsigned($signed({rm_val_i, 1'b0}) >>> sh_amt);
          reg_val = wide[DATA_W:1];
          reg_c   = wide[0];
        end
        SH_ROR: begin
          reg_val = rotr(rm_val_i, sh_amt);
          reg_c   = reg_val[DATA_W-1];
        end
        default: ;
      endcase
    end
  end

  assign op2_o = imm_sel_i ? imm_val : reg_val;
  assign shc_o = imm_sel_i ? imm_c   : reg_c;

  always_comb begin
    if (imm_sel_i && rot4 == '0)
      p_imm_norot_r2: assert (op2_o == DATA_W'(imm8) && shc_o == c_i)
        else $error("unrotated immediate altered");
    if (!imm_sel_i && sh_amt == '0)
      p_zero_shift_r3: assert (op2_o == rm_val_i && shc_o == c_i)
        else $error("zero shift altered operand");
  end

endmodule

// File: rtl/dpx_adder.sv
module dpx_adder #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);
  logic [DATA_W:0] full;

  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
  assign sum_o  = full[DATA_W-1:0];
  assign cout_o = full[DATA_W];
  assign ovf_o  = (a_i[DATA_W-1] == b_i[DATA_W-1]) && (sum_o[DATA_W-1] != a_i[DATA_W-1]);

endmodule

// File: rtl/dpx_alu.sv
module dpx_alu
  import dpx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] op1_i,
  input  logic [DATA_W-1:0] op2_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] result_o,
  output logic              add_c_o,
  output logic              add_v_o
);
  logic [DATA_W-1:0] add_a, add_b, add_sum;
  logic              add_cin;

  // subtraction = add inverted operand plus carry-in
  always_comb begin
    add_a   = op1_i;
    add_b   = op2_i;
    add_cin = 1'b0;
    unique case (op_i)
      OP_SUB, OP_CMP: begin add_b = ~op2_i;                   add_cin = 1'b1; end
      OP_RSB:         begin add_a = op2_i; add_b = ~op1_i;    add_cin = 1'b1; end
      OP_ADC:         begin                                   add_cin = c_i;  end
      OP_SBC:         begin add_b = ~op2_i;                   add_cin = c_i;  end
      OP_RSC:         begin add_a = op2_i; add_b = ~op1_i;    add_cin = c_i;  end
      default: ;
    endcase
  end

  dpx_adder #(.DATA_W(DATA_W)) u_add (
    .a_i   (add_a),
    .b_i   (add_b),
    .cin_i (add_cin),
    .sum_o (add_sum),
    .cout_o(add_c_o),
    .ovf_o (add_v_o)
  );

  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: result_o = op1_i & op2_i;
      OP_EOR, OP_TEQ: result_o = op1_i ^ op2_i;
      OP_ORR:         result_o = op1_i | op2_i;
      OP_MOV:         result_o = op2_i;
      OP_BIC:         result_o = op1_i & ~op2_i;
      OP_MVN:         result_o = ~op2_i;
      default:        result_o = add_sum;
    endcase
  end

  always_comb begin
    if (op_i == OP_ADD || op_i == OP_CMN)
      p_add_sum_r5: assert (result_o == op1_i + op2_i)
        else $error("add result mismatch");
    if (op_i == OP_SUB || op_i == OP_CMP)
      p_sub_diff_r5: assert (result_o == op1_i - op2_i)
        else $error("sub result mismatch");
  end

endmodule

// File: rtl/dpx_exec_unit.sv
module dpx_exec_unit
  import dpx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] rn_val_i,
  input  logic [DATA_W-1:0] rm_val_i,
  input  logic [3:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [RIDX_W-1:0] rd_idx_o,
  output logic              rd_we_o,
  output logic [3:0]        flags_o,
  output logic              flags_we_o
);
  alu_op_e           opc;
  logic              imm_sel, set_flg, test_op, arith_op;
  flags_t            f_in, f_out;
  logic [DATA_W-1:0] op2, res;
  logic              shc, add_c, add_v;
  logic [5:0]        unused_hdr;

  assign opc        = alu_op_e'(instr_i[FLD_OPC+3:FLD_OPC]);
  assign imm_sel    = instr_i[FLD_IMM];
  assign set_flg    = instr_i[FLD_SET];
  assign rd_idx_o   = instr_i[FLD_RD+RIDX_W-1:FLD_RD];
  assign unused_hdr = instr_i[DATA_W-1:FLD_IMM+1];
  assign test_op    = is_test(opc);
  assign arith_op   = is_arith(opc);
  assign f_in       = flags_t'(flags_i);

  dpx_operand2 #(.DATA_W(DATA_W)) u_op2 (
    .imm_sel_i(imm_sel),
    .field_i  (instr_i[OP2_W-1:0]),
    .rm_val_i (rm_val_i),
    .c_i      (f_in.c),
    .op2_o    (op2),
    .shc_o    (shc)
  );

  dpx_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (opc),
    .op1_i   (rn_val_i),
    .op2_i   (op2),
    .c_i     (f_in.c),
    .result_o(res),
    .add_c_o (add_c),
    .add_v_o (add_v)
  );

  assign result_o   = res;
  assign rd_we_o    = !test_op;
  assign flags_we_o = set_flg || test_op;

  always_comb begin
    f_out = f_in;
    if (flags_we_o) begin
      f_out.n = res[DATA_W-1];
      f_out.z = (res == '0);
      f_out.c = arith_op ? add_c : shc;
      f_out.v = arith_op ? add_v : f_in.v;
    end
  end

  assign flags_o = f_out;

  always_comb begin
    if (test_op)
      p_test_nowrite_r6: assert (!rd_we_o && flags_we_o)
        else $error("test opcode wrote register");
    if (!flags_we_o)
      p_flags_hold_r7: assert (flags_o == flags_i)
        else $error("flags changed without enable");
    if (flags_we_o)
      p_nz_track_r8: assert (flags_o[3] == result_o[DATA_W-1] && flags_o[2] == (result_o == '0))
        else $error("N/Z mismatch");
    if (flags_we_o && !arith_op)
      p_logic_v_keep_r10: assert (flags_o[0] == flags_i[0])
        else $error("logical op changed V");
  end

endmodule

// File: tb/sim_dpx_exec_unit.sv
module sim_dpx_exec_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr, rn_v, rm_v, result;
  logic [3:0]  flg_in, flg_out, rd_idx;
  logic        rd_we, flg_we;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  dpx_exec_unit u0 (
    .instr_i   (instr),
    .rn_val_i  (rn_v),
    .rm_val_i  (rm_v),
    .flags_i   (flg_in),
    .result_o  (result),
    .rd_idx_o  (rd_idx),
    .rd_we_o   (rd_we),
    .flags_o   (flg_out),
    .flags_we_o(flg_we)
  );

  function automatic logic [31:0] mk(bit i, logic [3:0] op, bit s, logic [3:0] rn, logic [3:0] rd, logic [11:0] o2);
    return {4'hE, 2'b00, i, op, s, rn, rd, o2};
  endfunction

  function automatic logic [11:0] sreg(logic [4:0] amt, logic [1:0] kind, logic [3:0] rm);
    return {amt, kind, 1'b0, rm};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] ins, logic [31:0] a, logic [31:0] b, logic [3:0] f);
    @(negedge clk);
    instr = ins; rn_v = a; rm_v = b; flg_in = f;
    #1;
  endtask

  task automatic t_basic_and;
    apply(mk(0, 4'h0, 0, 4'h3, 4'h9, sreg(0, 0, 1)), 32'hF0F0_0000, 32'hFF00_FF00, 4'b1010);
    chk("R4 and result", result, 32'hF000_0000);
    chk("R1 rd idx", rd_idx, 4'h9);
    chk("R6 and writes", rd_we, 1);
    chk("R7 no flag we", flg_we, 0);
    chk("R7 flags pass", flg_out, 4'b1010);
  endtask

  task automatic t_imm_add;
    apply(mk(1, 4'h4, 1, 4'h1, 4'h2, {4'd4, 8'hFF}), 32'h0100_0000, 32'h0, 4'b0000);
    chk("R2 R5 add imm", result, 32'h0);
    chk("R9 R12 add flags", flg_out, 4'b0110);
    apply(mk(1, 4'hD, 1, 4'h0, 4'h0, {4'd1, 8'h03}), 32'h0, 32'h0, 4'b0000);
    chk("R2 rotate 2", result, 32'hC000_0000);
    chk("R2 R10 rot carry", flg_out, 4'b1010);
    apply(mk(1, 4'hD, 1, 4'h0, 4'h0, {4'd0, 8'h55}), 32'h0, 32'h0, 4'b0011);
    chk("R2 rot0 value", result, 32'h55);
    chk("R2 rot0 carry kept", flg_out, 4'b0011);
  endtask

  task automatic t_arith;
    apply(mk(0, 4'h2, 1, 4'h0, 4'h0, sreg(0, 0, 0)), 32'd5, 32'd7, 4'b0000);
    chk("R5 sub", result, 32'hFFFF_FFFE);
    chk("R9 sub borrow", flg_out, 4'b1000);
    apply(mk(0, 4'h3, 1, 4'h0, 4'h0, sreg(0, 0, 0)), 32'd5, 32'd7, 4'b0000);
    chk("R5 rsb", result, 32'd2);
    chk("R9 rsb flags", flg_out, 4'b0010);
    apply(mk(0, 4'h5, 1, 4'h0, 4'h0, sreg(0, 0, 0)), 32'h7FFF_FFFF, 32'h0, 4'b0010);
    chk("R5 adc", result, 32'h8000_0000);
    chk("R9 adc overflow", flg_out, 4'b1001);
    apply(mk(0, 4'h6, 1, 4'h0, 4'h0, sreg(0, 0, 0)), 32'd10, 32'd3, 4'b0001);
    chk("R5 sbc c0", result, 32'd6);
    chk("R9 sbc flags", flg_out, 4'b0010);
    apply(mk(0, 4'h7, 1, 4'h0, 4'h0, sreg(0, 0, 0)), 32'd3, 32'd10, 4'b0010);
    chk("R5 rsc c1", result, 32'd7);
    chk("R9 rsc flags", flg_out, 4'b0010);
    apply(mk(0, 4'h4, 0, 4'h0, 4'h0, sreg(0, 0, 0)), 32'hFFFF_FFFF, 32'd1, 4'b0101);
    chk("R7 add s0 flags", flg_out, 4'b0101);
    chk("R7 add s0 we", flg_we, 0);
  endtask

  task automatic t_tests;
    apply(mk(0, 4'hA, 0, 4'h0, 4'h4, sreg(0, 0, 0)), 32'h8000_0000, 32'd1, 4'b0000);
    chk("R6 cmp no write", rd_we, 0);
    chk("R6 cmp flag we", flg_we, 1);
    chk("R9 cmp flags", flg_out, 4'b0011);
    apply(mk(0, 4'h8, 0, 4'h0, 4'h0, sreg(0, 0, 0)), 32'hF0, 32'h0F, 4'b0011);
    chk("R10 tst flags", flg_out, 4'b0111);
    chk("R6 tst no write", rd_we, 0);
    apply(mk(0, 4'h9, 0, 4'h0, 4'h0, sreg(0, 0, 0)), 32'hAA, 32'hAA, 4'b1000);
    chk("R4 teq result", result, 32'h0);
    chk("R8 teq flags", flg_out, 4'b0100);
    apply(mk(0, 4'hB, 0, 4'h0, 4'h0, sreg(0, 0, 0)), 32'hFFFF_FFFF, 32'd1, 4'b0000);
    chk("R9 cmn flags", flg_out, 4'b0110);
  endtask

  task automatic t_shifts;
    apply(mk(0, 4'hD, 1, 4'h0, 4'h0, sreg(1, 2'b00, 0)), 32'h0, 32'h8000_0001, 4'b0001);
    chk("R3 lsl", result, 32'h2);
    chk("R3 lsl carry", flg_out, 4'b0011);
    apply(mk(0, 4'hD, 1, 4'h0, 4'h0, sreg(1, 2'b01, 0)), 32'h0, 32'h8000_0001, 4'b0000);
    chk("R3 lsr", result, 32'h4000_0000);
    chk("R3 lsr carry", flg_out, 4'b0010);
    apply(mk(0, 4'hD, 1, 4'h0, 4'h0, sreg(4, 2'b10, 0)), 32'h0, 32'h8000_0000, 4'b0010);
    chk("R3 asr", result, 32'hF800_0000);
    chk("R3 asr carry", flg_out, 4'b1000);
    apply(mk(0, 4'hD, 1, 4'h0, 4'h0, sreg(4, 2'b11, 0)), 32'h0, 32'h0000_000F, 4'b0000);
    chk("R3 ror", result, 32'hF000_0000);
    chk("R3 ror carry", flg_out, 4'b1010);
    apply(mk(0, 4'hD, 1, 4'h0, 4'h0, sreg(0, 2'b01, 0)), 32'h0, 32'h1234_5678, 4'b0010);
    chk("R3 zero amount", result, 32'h1234_5678);
    chk("R3 zero amount carry", flg_out, 4'b0010);
    apply(mk(0, 4'hD, 1, 4'h0, 4'h0, sreg(1, 2'b00, 0)) | 32'h10, 32'h0, 32'h3, 4'b0000);
    chk("R3 bit4 ignored", result, 32'h6);
  endtask

  task automatic t_logic;
    apply(mk(0, 4'hE, 0, 4'h0, 4'h0, sreg(0, 0, 0)), 32'hFF, 32'h0F, 4'b0000);
    chk("R4 bic", result, 32'hF0);
    apply(mk(0, 4'hC, 0, 4'h0, 4'h0, sreg(0, 0, 0)), 32'hF0, 32'h0F, 4'b0000);
    chk("R4 orr", result, 32'hFF);
    apply(mk(0, 4'h1, 0, 4'h0, 4'h0, sreg(0, 0, 0)), 32'hFF, 32'h0F, 4'b0000);
    chk("R4 eor", result, 32'hF0);
    apply(mk(0, 4'hF, 1, 4'h0, 4'h0, sreg(0, 0, 0)), 32'h1234, 32'h0, 4'b0001);
    chk("R4 mvn", result, 32'hFFFF_FFFF);
    chk("R8 mvn flags", flg_out, 4'b1001);
  endtask

  task automatic t_ignore;
    apply(mk(0, 4'hD, 0, 4'h5, 4'h1, sreg(0, 0, 0)), 32'hDEAD_BEEF, 32'h55, 4'b0000);
    chk("R11 mov rn A", result, 32'h55);
    apply(mk(0, 4'hD, 0, 4'h5, 4'h1, sreg(0, 0, 0)), 32'h0, 32'h55, 4'b0000);
    chk("R11 mov rn B", result, 32'h55);
    apply(mk(0, 4'hF, 0, 4'h5, 4'h1, sreg(0, 0, 0)), 32'h1111, 32'h0F, 4'b0000);
    chk("R11 mvn rn", result, 32'hFFFF_FFF0);
    apply(mk(0, 4'h4, 1, 4'h0, 4'h7, sreg(0, 0, 0)) ^ 32'hFC00_0000, 32'd2, 32'd3, 4'b0000);
    chk("R1 header ignored", result, 32'd5);
    chk("R1 header flags", flg_out, 4'b0000);
    chk("R1 header rd", rd_idx, 4'h7);
  endtask

  initial begin
    instr = '0; rn_v = '0; rm_v = '0; flg_in = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_basic_and();
    t_imm_add();
    t_arith();
    t_tests();
    t_shifts();
    t_logic();
    t_ignore();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule